// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns single-cycle requests from a microcontroller core into the strobe sequence of a multiplexed external memory bus. The core runs a 12-clock machine cycle. Each accepted request fills exactly one machine cycle and is one of three kinds: a code fetch, an external data read or an external data write. The low byte lane carries first the low address byte, which the address-latch strobe (ALE) captures in an external latch, and then the data. The high byte lane carries the high address byte. For a short-address data access it carries the port 2 output latch value instead.

A free-running phase counter (0 to 11) times every strobe edge. In each machine cycle, ALE has two slots, and a code fetch has two program-store strobe slots. A data cycle gives up its second ALE slot and both program-store slots, and uses one long read or write strobe instead. A one-bit configuration register can mute ALE in idle cycles. The external-execution input overrides that register. Read data is taken from the low lane as the relevant strobe returns high. It is presented with a one-clock done pulse in the last phase of the access.

Top module: `xbus_seq`

## Requirements
- R1: While reset is applied, ale=0, psen_n=rd_n=wr_n=1, lo_oe=0, hi_oe=0, done=0 and req_ready=0.
- R2: In an idle machine cycle, with the ALE gate clear, ale is high in phases 0-1 and 6-7 and low in all other phases. Each pulse is exactly two clocks wide.
- R3: A code fetch (req_kind=2'd0) drives psen_n low in phases 3-5 and 9-11. It drives lo_out with addr[7:0] in phases 0-2 and with (addr+1)[7:0] in phases 6-8, and releases the low lane otherwise. hi_out carries addr[15:8] in phases 0-5 and (addr+1)[15:8] in phases 6-11. rd_n and wr_n stay high.
- R4: A code fetch captures lo_in in phase 5. That byte appears on rdata when done rises in phase 11.
- R5: A data read (req_kind=2'd1) pulses ale in phases 0-1 only and keeps psen_n high. It drives rd_n low in phases 5-10, drives the low lane only in phases 0-2, and captures lo_in in phase 10 for rdata.
- R6: A data write (req_kind=2'd2) pulses ale in phases 0-1 only. It drives wr_n low in phases 5-10 and drives the low lane in phases 0-2 (address) and 4-11 (write data). The low lane is released in phase 3.
- R7: For a data access, hi_out carries addr[15:8] when req_wide=1 and p2_latch when req_wide=0. hi_oe is high for the whole access cycle.
- R8: Requests are sampled only at the clock edge that ends phase 11, when req_ready is high. A request raised in any other phase produces no strobe until the following machine cycle. req_kind=2'd3 is taken as no access.
- R9: done is a one-clock pulse in phase 11 of each accepted access and never occurs in an idle cycle.
- R10: A write with sfr_we=1 and sfr_addr=8'h8E loads the ALE gate from sfr_wbit. When the gate is set and ext_exec=0, ale stays low in idle cycles but still pulses for accesses. Writes to other addresses leave the gate unchanged.
- R11: When ext_exec=1, the ALE gate has no effect and idle cycles pulse ale twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 code fetch, 1 data read, 2 data write, 3 none |
| req_wide | input | 1 | Data access uses a 16-bit address |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | High in phase 11; a request is taken at that edge |
| done | output | 1 | One-clock pulse in the last phase of an access |
| rdata | output | 8 | Captured read or fetch byte |
| sfr_we | input | 1 | Configuration write strobe |
| sfr_addr | input | 8 | Configuration write address |
| sfr_wbit | input | 1 | Bit 0 of the configuration write data |
| ext_exec | input | 1 | Core executes from external program memory |
| p2_latch | input | 8 | Port 2 output latch value |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low lane value (address then data) |
| lo_oe | output | 1 | Low lane drive enable |
| lo_in | input | 8 | Low lane value from the pads |
| hi_out | output | 8 | High lane value |
| hi_oe | output | 1 | High lane drive enable |

## Verification
A request presented in phase 11 is taken at that edge. Its strobes change on the very next edge, which starts phase 0. A captured byte becomes visible one edge after its capture phase (5 or 10) and is still held in phase 11, together with done. The bench waits for req_ready, drives the request, and then samples every output on the falling edge inside each of the 12 following phases. It packs each output into a per-phase map and compares that map with a mask derived from the phase windows in the requirements. It checks lane values only in the phases where they are due. lo_in carries the inverted byte in every phase except the capture phase, so a capture one clock early or late gives the wrong value.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  // Phase windows, counted from the start of a machine cycle (or half cycle)
  localparam int ALE_LEN    = 2;
  localparam int ADR_END    = ALE_LEN;                  // address held one clock past ALE fall
  localparam int CODE_START = ALE_LEN + 1;
  localparam int CODE_LEN   = 3;
  localparam int CODE_END   = CODE_START + CODE_LEN - 1;
  localparam int DATA_START = ALE_LEN + 3;
  localparam int DATA_LEN   = 6;
  localparam int DATA_END   = DATA_START + DATA_LEN - 1;
  localparam int WD_START   = DATA_START - 1;           // write data setup
  localparam int WD_END     = DATA_END + 1;             // write data hold

  function automatic logic in_win(input int p, input int lo, input int hi);
    return (p >= lo) && (p <= hi);
  endfunction

endpackage

// File: rtl/xbs_phase_ctr.sv
module xbs_phase_ctr #(
  parameter int CYC_LEN = 12,
  parameter int PH_W    = $clog2(CYC_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase,
  output logic            at_end
);
  localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            run_q, run_d;

  always_comb begin
    run_d = 1'b1;
    ph_d  = ph_q;
    if (run_q) begin
      ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= LAST;
      run_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      run_q <= run_d;
    end
  end

  assign phase  = ph_q;
  assign at_end = run_q && (ph_q == LAST);
endmodule

// File: rtl/xbs_cfg_reg.sv
module xbs_cfg_reg #(
  parameter int             AW       = 8,
  parameter logic [AW-1:0]  CFG_ADDR = 8'h8E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          wbit,
  output logic          ale_off
);
  logic off_q, off_d;

  always_comb begin
    off_d = off_q;
    if (we && (addr == CFG_ADDR)) begin
      off_d = wbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= 1'b0;
    else        off_q <= off_d;
  end

  assign ale_off = off_q;
endmodule

// File: rtl/xbs_strobe_gen.sv
module xbs_strobe_gen
  import xbs_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int PH_W    = $clog2(CYC_LEN)
) (
  input  logic [PH_W-1:0] phase,
  input  acc_kind_e       kind,
  input  logic            ext_exec,
  input  logic            ale_off,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic            done
);
  localparam int HALF = CYC_LEN / 2;

  int   ph_i;
  logic slot_a, slot_b, gate_ok, is_data, code_win, data_win;

  assign ph_i = int'(phase);

  always_comb begin
    slot_a   = in_win(ph_i, 0, ALE_LEN - 1);
    slot_b   = in_win(ph_i, HALF, HALF + ALE_LEN - 1);
    is_data  = (kind == ACC_READ) || (kind == ACC_WRITE);
    // The gate only mutes idle cycles; external execution overrides it
    gate_ok  = (kind != ACC_NONE) || ext_exec || !ale_off;
    code_win = in_win(ph_i, CODE_START, CODE_END) ||
               in_win(ph_i, HALF + CODE_START, HALF + CODE_END);
    data_win = in_win(ph_i, DATA_START, DATA_END);

    ale    = gate_ok && (slot_a || (slot_b && !is_data));
    psen_n = !((kind == ACC_FETCH) && code_win);
    rd_n   = !((kind == ACC_READ)  && data_win);
    wr_n   = !((kind == ACC_WRITE) && data_win);
    done   = (kind != ACC_NONE) && (ph_i == CYC_LEN - 1);
  end
endmodule

// File: rtl/xbs_lane_ctl.sv
module xbs_lane_ctl
  import xbs_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int PH_W    = $clog2(CYC_LEN),
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int HI_W    = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   phase,
  input  acc_kind_e         kind,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [HI_W-1:0]   p2_latch,
  input  logic [DATA_W-1:0] lo_in,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              hi_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int HALF = CYC_LEN / 2;

  int                ph_i;
  logic [ADDR_W-1:0] addr_nx;
  logic              second_half, cap_en;
  logic [DATA_W-1:0] rd_q, rd_d;

  assign ph_i    = int'(phase);
  assign addr_nx = addr + ADDR_W'(1);

  always_comb begin
    second_half = (ph_i >= HALF);

    lo_oe = 1'b0;
    if (kind != ACC_NONE) begin
      lo_oe = in_win(ph_i, 0, ADR_END) ||
              ((kind == ACC_FETCH) && in_win(ph_i, HALF, HALF + ADR_END)) ||
              ((kind == ACC_WRITE) && in_win(ph_i, WD_START, WD_END));
    end

    if ((kind == ACC_FETCH) && second_half)             lo_out = addr_nx[DATA_W-1:0];
    else if ((kind == ACC_WRITE) && (ph_i >= WD_START)) lo_out = wdata;
    else                                                lo_out = addr[DATA_W-1:0];

    hi_oe = (kind != ACC_NONE);
    if (kind == ACC_FETCH) hi_out = second_half ? addr_nx[ADDR_W-1 -: HI_W] : addr[ADDR_W-1 -: HI_W];
    else if (wide)         hi_out = addr[ADDR_W-1 -: HI_W];
    else                   hi_out = p2_latch;

    // Capture on the edge where the active read strobe returns high
    cap_en = ((kind == ACC_FETCH) && (ph_i == CODE_END)) ||
             ((kind == ACC_READ)  && (ph_i == DATA_END));
    rd_d   = cap_en ? lo_in : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbs_pkg::*;
#(
  parameter int                CYC_LEN  = 12,
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                SFR_AW   = 8,
  parameter logic [SFR_AW-1:0] CFG_ADDR = 8'h8E
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [1:0]                req_kind,
  input  logic                      req_wide,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      req_ready,
  output logic                      done,
  output logic [DATA_W-1:0]         rdata,
  input  logic                      sfr_we,
  input  logic [SFR_AW-1:0]         sfr_addr,
  input  logic                      sfr_wbit,
  input  logic                      ext_exec,
  input  logic [ADDR_W-DATA_W-1:0]  p2_latch,
  output logic                      ale,
  output logic                      psen_n,
  output logic                      rd_n,
  output logic                      wr_n,
  output logic [DATA_W-1:0]         lo_out,
  output logic                      lo_oe,
  input  logic [DATA_W-1:0]         lo_in,
  output logic [ADDR_W-DATA_W-1:0]  hi_out,
  output logic                      hi_oe
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam int PH_W = $clog2(CYC_LEN);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [PH_W-1:0] phase;
  logic            at_end, ale_off;

  xbs_phase_ctr #(.CYC_LEN(CYC_LEN), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_int_n), .phase(phase), .at_end(at_end)
  );

  xbs_cfg_reg #(.AW(SFR_AW), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .we(sfr_we), .addr(sfr_addr),
    .wbit(sfr_wbit), .ale_off(ale_off)
  );

  // Access slot: loaded only at the machine-cycle boundary
  acc_kind_e         kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              wide_q, wide_d;

  always_comb begin
    kind_d  = kind_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    wide_d  = wide_q;
    if (at_end) begin
      kind_d = ACC_NONE;
      if (req_valid) begin
        kind_d  = acc_kind_e'(req_kind);
        addr_d  = req_addr;
        wdata_d = req_wdata;
        wide_d  = req_wide;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      kind_q  <= ACC_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
      wide_q  <= 1'b0;
    end else begin
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      wide_q  <= wide_d;
    end
  end

  assign req_ready = at_end;

  xbs_strobe_gen #(.CYC_LEN(CYC_LEN), .PH_W(PH_W)) u_strobe (
    .phase(phase), .kind(kind_q), .ext_exec(ext_exec), .ale_off(ale_off),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .done(done)
  );

  xbs_lane_ctl #(
    .CYC_LEN(CYC_LEN), .PH_W(PH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_W(HI_W)
  ) u_lane (
    .clk(clk), .rst_n(rst_int_n), .phase(phase), .kind(kind_q), .wide(wide_q),
    .addr(addr_q), .wdata(wdata_q), .p2_latch(p2_latch), .lo_in(lo_in),
    .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .hi_oe(hi_oe), .rdata(rdata)
  );
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              ale,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              lo_oe,
  input logic [DATA_W-1:0] lo_out
);
  p_ale_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);
  p_ale_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> ##2 !ale);
  p_psen_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (!ale && !lo_oe));
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);
  p_rd_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !lo_oe);
  p_wr_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> (lo_oe && $stable(lo_out)));
  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (lo_oe && $stable(lo_out)));
  p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

bind xbus_seq xbus_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .ale(ale),
  .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .lo_oe(lo_oe), .lo_out(lo_out)
);

// File: tb/xbus_seq_tb_top.sv
module xbus_seq_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, req_wide, req_ready, done, sfr_we, sfr_wbit, ext_exec;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, rdata, sfr_addr, p2_latch, lo_out, lo_in, hi_out;
  logic        ale, psen_n, rd_n, wr_n, lo_oe, hi_oe;

  xbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wbit(sfr_wbit), .ext_exec(ext_exec),
    .p2_latch(p2_latch), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out), .hi_oe(hi_oe)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [11:0] v_ale, v_psen, v_rd, v_wr, v_loe, v_hoe, v_done;
  logic [7:0]  s_lo [12];
  logic [7:0]  s_hi [12];
  logic [7:0]  s_rdata;

  task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic sync_end();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic to_phase3();
    sync_end();
    repeat (4) @(negedge clk);
  endtask

  // At the phase-11 falling edge with the request driven: sample phases 0..11
  task automatic walk(input int cap, input logic [7:0] inb);
    for (int p = 0; p < 12; p++) begin
      @(negedge clk);
      if (p == 0) req_valid = 1'b0;
      v_ale[p]  = ale;     v_psen[p] = !psen_n;
      v_rd[p]   = !rd_n;   v_wr[p]   = !wr_n;
      v_loe[p]  = lo_oe;   v_hoe[p]  = hi_oe;
      v_done[p] = done;
      s_lo[p]   = lo_out;  s_hi[p]   = hi_out;
      lo_in     = (p == cap) ? inb : ~inb;
    end
    s_rdata = rdata;
  endtask

  task automatic run_cycle(input logic valid, input logic [1:0] kind, input logic wide,
                           input logic [15:0] addr, input logic [7:0] wd,
                           input logic [7:0] inb, input int cap);
    sync_end();
    req_valid = valid; req_kind = kind; req_wide = wide;
    req_addr = addr;   req_wdata = wd;   lo_in = ~inb;
    walk(cap, inb);
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic b);
    to_phase3();
    sfr_we = 1'b1; sfr_addr = a; sfr_wbit = b;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "ale", 16'(ale), 16'h0);
    chk("R1", "strobes", 16'({psen_n, rd_n, wr_n}), 16'h7);
    chk("R1", "lane enables", 16'({lo_oe, hi_oe}), 16'h0);
    chk("R1", "done", 16'(done), 16'h0);
    chk("R1", "req_ready", 16'(req_ready), 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_idle();
    run_cycle(1'b0, 2'd3, 1'b0, 16'h0, 8'h0, 8'h0, 99);
    chk("R2", "idle ale map", 16'(v_ale), 16'h0C3);
    chk("R9", "idle done map", 16'(v_done), 16'h000);
    chk("R2", "idle psen map", 16'(v_psen), 16'h000);
  endtask

  task automatic t_fetch();
    run_cycle(1'b1, 2'd0, 1'b0, 16'h12FF, 8'h00, 8'hA5, 5);
    chk("R3", "fetch psen map", 16'(v_psen), 16'hE38);
    chk("R3", "fetch rd/wr map", 16'(v_rd | v_wr), 16'h000);
    chk("R3", "fetch ale map", 16'(v_ale), 16'h0C3);
    chk("R3", "fetch lo_oe map", 16'(v_loe), 16'h1C7);
    chk("R3", "fetch lo ph1", 16'(s_lo[1]), 16'h00FF);
    chk("R3", "fetch lo ph7", 16'(s_lo[7]), 16'h0000);
    chk("R3", "fetch hi ph1", 16'(s_hi[1]), 16'h0012);
    chk("R3", "fetch hi ph7", 16'(s_hi[7]), 16'h0013);
    chk("R4", "fetch rdata", 16'(s_rdata), 16'h00A5);
    chk("R9", "fetch done map", 16'(v_done), 16'h800);
  endtask

  task automatic t_read();
    p2_latch = 8'h5A;
    run_cycle(1'b1, 2'd1, 1'b0, 16'h003C, 8'h00, 8'h96, 10);
    chk("R5", "read ale map", 16'(v_ale), 16'h003);
    chk("R5", "read rd map", 16'(v_rd), 16'h7E0);
    chk("R5", "read psen/wr map", 16'(v_psen | v_wr), 16'h000);
    chk("R5", "read lo_oe map", 16'(v_loe), 16'h007);
    chk("R5", "read rdata", 16'(s_rdata), 16'h0096);
    chk("R7", "narrow hi uses p2", 16'(s_hi[1]), 16'h005A);
    chk("R7", "hi_oe map", 16'(v_hoe), 16'hFFF);
    chk("R9", "read done map", 16'(v_done), 16'h800);
    run_cycle(1'b1, 2'd1, 1'b1, 16'hBEEF, 8'h00, 8'h3C, 10);
    chk("R7", "wide hi addr", 16'(s_hi[1]), 16'h00BE);
    chk("R5", "wide lo addr", 16'(s_lo[1]), 16'h00EF);
    chk("R5", "wide rdata", 16'(s_rdata), 16'h003C);
  endtask

  task automatic t_write();
    p2_latch = 8'h5A;
    run_cycle(1'b1, 2'd2, 1'b0, 16'h0077, 8'hC3, 8'h00, 99);
    chk("R6", "write wr map", 16'(v_wr), 16'h7E0);
    chk("R6", "write rd/psen map", 16'(v_rd | v_psen), 16'h000);
    chk("R6", "write ale map", 16'(v_ale), 16'h003);
    chk("R6", "write lo_oe map", 16'(v_loe), 16'hFF7);
    chk("R6", "write lo ph1", 16'(s_lo[1]), 16'h0077);
    chk("R6", "write data setup ph4", 16'(s_lo[4]), 16'h00C3);
    chk("R6", "write data hold ph11", 16'(s_lo[11]), 16'h00C3);
    chk("R7", "write narrow hi", 16'(s_hi[2]), 16'h005A);
  endtask

  task automatic t_accept();
    logic [11:0] m_rd, m_rdy;
    m_rd = '0; m_rdy = '0;
    sync_end();
    repeat (4) @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd1; req_wide = 1'b1;
    req_addr = 16'h4411; req_wdata = 8'h00; lo_in = 8'h00;
    m_rd[3] = !rd_n; m_rdy[3] = req_ready;
    for (int p = 4; p < 12; p++) begin
      @(negedge clk);
      m_rd[p] = !rd_n; m_rdy[p] = req_ready;
    end
    chk("R8", "late request: no rd", 16'(m_rd), 16'h000);
    chk("R8", "ready only ph11", 16'(m_rdy), 16'h800);
    lo_in = ~8'h6E;
    walk(10, 8'h6E);
    chk("R8", "deferred read rd map", 16'(v_rd), 16'h7E0);
    chk("R8", "deferred read rdata", 16'(s_rdata), 16'h006E);
    run_cycle(1'b1, 2'd3, 1'b0, 16'h1234, 8'h00, 8'h00, 99);
    chk("R8", "kind 3 done map", 16'(v_done), 16'h000);
    chk("R8", "kind 3 lo_oe map", 16'(v_loe), 16'h000);
  endtask

  task automatic t_gate();
    sfr_write(8'h8E, 1'b1);
    run_cycle(1'b0, 2'd3, 1'b0, 16'h0, 8'h0, 8'h0, 99);
    chk("R10", "gated idle ale", 16'(v_ale), 16'h000);
    run_cycle(1'b1, 2'd1, 1'b1, 16'h2222, 8'h0, 8'h11, 10);
    chk("R10", "gated read ale", 16'(v_ale), 16'h003);
    run_cycle(1'b1, 2'd0, 1'b0, 16'h0100, 8'h0, 8'h22, 5);
    chk("R10", "gated fetch ale", 16'(v_ale), 16'h0C3);
    sfr_write(8'h8F, 1'b0);
    run_cycle(1'b0, 2'd3, 1'b0, 16'h0, 8'h0, 8'h0, 99);
    chk("R10", "other addr no effect", 16'(v_ale), 16'h000);
    to_phase3();
    ext_exec = 1'b1;
    run_cycle(1'b0, 2'd3, 1'b0, 16'h0, 8'h0, 8'h0, 99);
    chk("R11", "ext exec overrides gate", 16'(v_ale), 16'h0C3);
    to_phase3();
    ext_exec = 1'b0;
    sfr_write(8'h8E, 1'b0);
    run_cycle(1'b0, 2'd3, 1'b0, 16'h0, 8'h0, 8'h0, 99);
    chk("R10", "gate cleared", 16'(v_ale), 16'h0C3);
  endtask

  initial begin
    req_valid = 0; req_kind = 2'd3; req_wide = 0; req_addr = '0; req_wdata = '0;
    sfr_we = 0; sfr_addr = '0; sfr_wbit = 0; ext_exec = 0; p2_latch = '0; lo_in = '0;
    t_reset();
    t_idle();
    t_fetch();
    t_read();
    t_write();
    t_accept();
    t_gate();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule